// File: doc/BRIEF.md
# Prioritized CPU Event Acceptance Controller

This block decides, every clock cycle, which pending processor event is taken. It sees four interrupt levels, a set of general exception requests, four critical events (non-maskable interrupt, unrecoverable exception, address-translation multiple hit, bus error) and a debug request. It also holds the status mask vector that gates them. When an event wins, the block raises a same-cycle accept strobe for the context sequencer. Along with the strobe it gives the event's identifier, the execution-mode code to enter and the handler address to load into the program counter. On the following clock edge the block sets the mask bits of every source of equal or lower priority.

Requests are level signals held by their sources until they see the accept strobe; the block keeps no copy of them. Software may overwrite the mask vector through a one-cycle write port, for example to clear masks and allow nesting. The critical events ignore every mask.

Top module: `evt_accept_ctrl`

## Requirements
- R1: After reset the mask vector is 7'h3F: debug mask (bit 6) clear; global (bit 5), exception (bit 4) and interrupt-level masks (bits 3..0, bit L for level L) set. With no request pending, the accept strobe is low.
- R2: Priority from highest to lowest is debug, critical, exception, then interrupt levels 3, 2, 1, 0. Within the critical or exception class the lowest index wins. Identifiers are: 0 for debug, 1+i for critical i, 5+i for exception i, and 9+(3-L) for interrupt level L.
- R3: Interrupt level L is accepted only when mask bits L and 5 are both clear. An exception is accepted only when bit 4 is clear. Debug is accepted only when bit 6 is clear. A masked source is passed over in favour of the next eligible one.
- R4: A pending critical event is accepted whatever the mask vector holds, unless an unmasked debug request is present.
- R5: On the edge after an acceptance, the following mask bits become set, and the rest keep their value. Interrupt level L sets bits L..0. An exception sets bits 4 and 5. A critical event sets bits 5..0. Debug sets all seven bits.
- R6: The mode code is L+1 for interrupt level L, 5 for an exception, 6 for a critical event and 7 for debug. It is 0 when nothing is accepted.
- R7: The handler address is 32'h0000_1000 plus four times the identifier, and 0 when nothing is accepted.
- R8: A mask write replaces the mask vector on the next edge. If an acceptance happens in the same cycle, its set bits are ORed onto the written value.
- R9: Requests are not stored. A request that is withdrawn before it is accepted leaves no later acceptance. A request held while masked is accepted in the cycle its mask clears.
- R10: The accept strobe, identifier, mode and address follow the inputs in the same cycle. With no acceptance and no write, the mask vector is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 4 | Interrupt request per level, bit L for level L |
| exc_req | input | 4 | General exception requests |
| crit_req | input | 4 | Critical non-maskable event requests |
| dbg_req | input | 1 | Debug entry request |
| mask_we | input | 1 | Software mask write enable |
| mask_wdata | input | 7 | Mask value to write |
| evt_accept | output | 1 | Accept strobe for the context sequencer |
| evt_id | output | 4 | Identifier of the accepted event |
| evt_mode | output | 3 | Execution-mode code to enter |
| evt_handler | output | 32 | Handler address for the program counter |
| mask_q | output | 7 | Current mask vector |

## Verification
The hardest situations to reach are a software mask write that lands in the same cycle as an acceptance, and a request that is withdrawn while masked before its mask is cleared. Both depend on exact cycle placement against the registered mask. The bench reaches them with directed sequences driven on the falling edge. It writes a chosen mask, raises or drops single requests on chosen cycles, and reads the mask back at the ports. Around these cases it sweeps all 128 mask values against 24 request patterns from a shift register per mask. Some patterns are sparse, and the critical and debug lines are suppressed on part of them so that the lower classes are also exercised.

// File: rtl/evt_pkg.sv
// Package: shared event class type for the acceptance controller.
// Assumes: one class is chosen per cycle, CLS_NONE when idle.
package evt_pkg;
    typedef enum logic [2:0] {
        CLS_NONE = 3'd0,
        CLS_IRQ  = 3'd1,
        CLS_EXC  = 3'd2,
        CLS_CRIT = 3'd3,
        CLS_DBG  = 3'd4
    } evt_class_e;
endpackage

// File: rtl/evt_first_set.sv
// Module: finds the lowest-index set bit of a request vector.
// Assumes: W >= 1; idx is zero when nothing is set.
module evt_first_set #(
    parameter int W  = 4,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from the top down so that the lowest set index is kept last.
    always_comb begin
        found = |req;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) idx = IW'(i);
        end
        if (found) begin
            assert_pick_valid_R2: assert (req[idx]);
        end
    end
endmodule

// File: rtl/evt_mask_set.sv
// Module: builds the mask bits to set for an accepted event class.
// Assumes: layout [NUM_IRQ-1:0] levels, then exception, global, debug.
module evt_mask_set #(
    parameter int NUM_IRQ = 4,
    localparam int LW     = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1,
    localparam int MW     = NUM_IRQ + 3
) (
    input  evt_pkg::evt_class_e cls,
    input  logic [LW-1:0]       lvl,
    output logic [MW-1:0]       set_bits
);
    import evt_pkg::*;

    // One term per interrupt level: that level and every lower one.
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_lvl
        assign set_bits[i] = ((cls == CLS_IRQ) && (lvl >= LW'(i)))
                           || (cls == CLS_CRIT) || (cls == CLS_DBG);
    end

    // Exception and global masks: set by exceptions and anything above.
    assign set_bits[NUM_IRQ]     = (cls == CLS_EXC) || (cls == CLS_CRIT) || (cls == CLS_DBG);
    assign set_bits[NUM_IRQ + 1] = (cls == CLS_EXC) || (cls == CLS_CRIT) || (cls == CLS_DBG);
    // Debug mask: only debug acceptance sets it.
    assign set_bits[NUM_IRQ + 2] = (cls == CLS_DBG);
endmodule

// File: rtl/evt_accept_ctrl.sv
// Module: top of the event acceptance controller. It picks the highest
// priority eligible event each cycle, strobes it out at once and updates
// the registered mask vector on the next edge.
// Assumes: sources hold their requests until they see evt_accept; the
// mask write port and acceptance may coincide (their bits are ORed).
module evt_accept_ctrl #(
    parameter int NUM_IRQ        = 4,
    parameter int NUM_EXC        = 4,
    parameter int NUM_CRIT       = 4,
    parameter int ADDR_W         = 32,
    parameter logic [ADDR_W-1:0] HANDLER_BASE = 32'h0000_1000,
    parameter int HANDLER_STRIDE = 4,
    parameter logic [NUM_IRQ+2:0] MASK_RST = {1'b0, {(NUM_IRQ + 2){1'b1}}},
    localparam int MASK_W = NUM_IRQ + 3,
    localparam int EXC_B  = NUM_IRQ,
    localparam int GLB_B  = NUM_IRQ + 1,
    localparam int DBG_B  = NUM_IRQ + 2,
    localparam int NUM_EV = 1 + NUM_CRIT + NUM_EXC + NUM_IRQ,
    localparam int ID_W   = $clog2(NUM_EV),
    localparam int MODE_W = $clog2(NUM_IRQ + 4)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IRQ-1:0]  irq_req,
    input  logic [NUM_EXC-1:0]  exc_req,
    input  logic [NUM_CRIT-1:0] crit_req,
    input  logic                dbg_req,
    input  logic                mask_we,
    input  logic [MASK_W-1:0]   mask_wdata,
    output logic                evt_accept,
    output logic [ID_W-1:0]     evt_id,
    output logic [MODE_W-1:0]   evt_mode,
    output logic [ADDR_W-1:0]   evt_handler,
    output logic [MASK_W-1:0]   mask_q
);
    import evt_pkg::*;

    localparam int LW = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;
    localparam int EW = (NUM_EXC > 1) ? $clog2(NUM_EXC) : 1;
    localparam int CW = (NUM_CRIT > 1) ? $clog2(NUM_CRIT) : 1;

    logic [NUM_IRQ-1:0] irq_ok;
    logic [NUM_IRQ-1:0] irq_rev;
    logic [NUM_EXC-1:0] exc_ok;
    logic               dbg_ok;
    logic               irq_found, exc_found, crit_found;
    logic [LW-1:0]      irq_ridx, irq_lvl;
    logic [EW-1:0]      exc_idx;
    logic [CW-1:0]      crit_idx;
    evt_class_e         cls;
    logic [MASK_W-1:0]  set_bits;

    // Eligibility of each interrupt level: own mask and global mask clear.
    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_irq
        assign irq_ok[i]                = irq_req[i] & ~mask_q[i] & ~mask_q[GLB_B];
        assign irq_rev[NUM_IRQ - 1 - i] = irq_ok[i];
    end

    // Exceptions are gated by the exception mask only; debug by its own.
    assign exc_ok = exc_req & {NUM_EXC{~mask_q[EXC_B]}};
    assign dbg_ok = dbg_req & ~mask_q[DBG_B];

    evt_first_set #(.W(NUM_IRQ)) u_pick_irq (
        .req(irq_rev), .found(irq_found), .idx(irq_ridx)
    );
    evt_first_set #(.W(NUM_EXC)) u_pick_exc (
        .req(exc_ok), .found(exc_found), .idx(exc_idx)
    );
    evt_first_set #(.W(NUM_CRIT)) u_pick_crit (
        .req(crit_req), .found(crit_found), .idx(crit_idx)
    );

    // Reversed pick index back to the interrupt level number.
    assign irq_lvl = LW'(NUM_IRQ - 1) - irq_ridx;

    // Class arbitration and identifier / mode selection.
    always_comb begin
        cls      = CLS_NONE;
        evt_id   = '0;
        evt_mode = '0;
        if (dbg_ok) begin
            cls      = CLS_DBG;
            evt_id   = '0;
            evt_mode = MODE_W'(NUM_IRQ + 3);
        end else if (crit_found) begin
            cls      = CLS_CRIT;
            evt_id   = ID_W'(1) + ID_W'(crit_idx);
            evt_mode = MODE_W'(NUM_IRQ + 2);
        end else if (exc_found) begin
            cls      = CLS_EXC;
            evt_id   = ID_W'(1 + NUM_CRIT) + ID_W'(exc_idx);
            evt_mode = MODE_W'(NUM_IRQ + 1);
        end else if (irq_found) begin
            cls      = CLS_IRQ;
            evt_id   = ID_W'(1 + NUM_CRIT + NUM_EXC) + ID_W'(irq_ridx);
            evt_mode = MODE_W'(irq_lvl) + MODE_W'(1);
        end
    end

    assign evt_accept = (cls != CLS_NONE);

    // Handler address: fixed base plus a slot per identifier.
    assign evt_handler = evt_accept
        ? HANDLER_BASE + ADDR_W'(evt_id) * ADDR_W'(HANDLER_STRIDE)
        : '0;

    evt_mask_set #(.NUM_IRQ(NUM_IRQ)) u_mask_set (
        .cls(cls), .lvl(irq_lvl), .set_bits(set_bits)
    );

    // Mask register: software write, then acceptance bits ORed on top.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= MASK_RST;
        else        mask_q <= (mask_we ? mask_wdata : mask_q) | set_bits;
    end

    // A critical request wins unless unmasked debug is present.
    assert_crit_unmasked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((|crit_req) && !(dbg_req && !mask_q[DBG_B]))
        |-> (evt_accept && evt_mode == MODE_W'(NUM_IRQ + 2)));

    // An accepted interrupt level had both its level and global masks clear.
    assert_irq_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_accept && evt_mode >= MODE_W'(1) && evt_mode <= MODE_W'(NUM_IRQ))
        |-> (!mask_q[GLB_B] && !mask_q[evt_mode - MODE_W'(1)]));

    // An accepted exception had the exception mask clear.
    assert_exc_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_accept && evt_mode == MODE_W'(NUM_IRQ + 1)) |-> !mask_q[EXC_B]);

    // Exception acceptance leaves exception and global masks set.
    assert_exc_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_accept && evt_mode == MODE_W'(NUM_IRQ + 1)) |=> (mask_q[EXC_B] && mask_q[GLB_B]));

    // Debug acceptance leaves every mask bit set.
    assert_dbg_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_accept && evt_mode == MODE_W'(NUM_IRQ + 3)) |=> (&mask_q));

    // With nothing pending and no write, the mask holds.
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|irq_req) && !(|exc_req) && !(|crit_req) && !dbg_req && !mask_we)
        |=> $stable(mask_q));

    // Nothing pending means no accept strobe.
    assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|irq_req) && !(|exc_req) && !(|crit_req) && !dbg_req) |-> !evt_accept);
endmodule

// File: tb/evt_accept_ctrl_tb.sv
module evt_accept_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] BASE = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  irq_req = '0, exc_req = '0, crit_req = '0;
    logic        dbg_req = 1'b0;
    logic        mask_we = 1'b0;
    logic [6:0]  mask_wdata = '0;
    logic        evt_accept;
    logic [3:0]  evt_id;
    logic [2:0]  evt_mode;
    logic [31:0] evt_handler;
    logic [6:0]  mask_q;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    evt_accept_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .exc_req(exc_req),
        .crit_req(crit_req), .dbg_req(dbg_req), .mask_we(mask_we),
        .mask_wdata(mask_wdata), .evt_accept(evt_accept), .evt_id(evt_id),
        .evt_mode(evt_mode), .evt_handler(evt_handler), .mask_q(mask_q)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Expected behaviour from the requirements (R2..R7).
    task automatic model(input logic [6:0] m, input logic [3:0] ir, input logic [3:0] ex,
                         input logic [3:0] cr, input logic db,
                         output logic acc, output logic [3:0] id,
                         output logic [2:0] mode, output logic [6:0] set);
        acc = 1'b0; id = '0; mode = '0; set = '0;
        if (db && !m[6]) begin
            acc = 1'b1; id = 4'd0; mode = 3'd7; set = 7'h7F;
        end else if (cr != 0) begin
            for (int i = 3; i >= 0; i--) if (cr[i]) id = 4'(1 + i);
            acc = 1'b1; mode = 3'd6; set = 7'h3F;
        end else if (ex != 0 && !m[4]) begin
            for (int i = 3; i >= 0; i--) if (ex[i]) id = 4'(5 + i);
            acc = 1'b1; mode = 3'd5; set = 7'h30;
        end else begin
            for (int l = 0; l < 4; l++) begin
                if (ir[l] && !m[5] && !m[l]) begin
                    acc = 1'b1; id = 4'(9 + 3 - l); mode = 3'(l + 1);
                    set = 7'((1 << (l + 1)) - 1);
                end
            end
        end
    endtask

    task automatic write_mask(input logic [6:0] m);
        @(negedge clk);
        mask_we = 1'b1; mask_wdata = m;
        @(negedge clk);
        mask_we = 1'b0;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog act=%h exp=%h", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic        acc;
        logic [3:0]  id;
        logic [2:0]  mode;
        logic [6:0]  set;
        logic [15:0] lfsr = 16'hACE1;
        logic [3:0]  ir, ex, cr;
        logic        db;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 mask reset", 32'(mask_q), 32'h3F);
        check("R1 idle accept", 32'(evt_accept), 32'h0);

        // R8: write replaces mask
        write_mask(7'h00);
        check("R8 write", 32'(mask_q), 32'h00);

        // R8: write and acceptance in the same cycle (level 2 sets bits 2..0)
        @(negedge clk);
        mask_we = 1'b1; mask_wdata = 7'h40; irq_req = 4'b0100;
        #1 check("R10 same-cycle accept", 32'(evt_accept), 32'h1);
        @(negedge clk);
        mask_we = 1'b0; irq_req = '0;
        check("R8 write OR accept", 32'(mask_q), 32'h47);

        // R5 nesting: level 1 accepted, then held level 1 blocked, level 2 taken
        write_mask(7'h00);
        irq_req = 4'b0010;
        #1 check("R6 level1 mode", 32'(evt_mode), 32'h2);
        @(negedge clk);
        check("R5 level1 sets", 32'(mask_q), 32'h03);
        check("R3 level1 now masked", 32'(evt_accept), 32'h0);
        irq_req = 4'b0110;
        #1 check("R2 level2 id", 32'(evt_id), 32'd10);
        @(negedge clk);
        irq_req = '0;
        check("R5 level2 sets", 32'(mask_q), 32'h07);

        // R9: withdrawn masked request leaves nothing behind
        write_mask(7'h3F);
        irq_req = 4'b0001;
        @(negedge clk);
        irq_req = '0;
        write_mask(7'h00);
        #1 check("R9 no latched request", 32'(evt_accept), 32'h0);
        @(negedge clk);
        check("R10 mask holds idle", 32'(mask_q), 32'h00);

        // R9: held masked request taken when the mask clears
        write_mask(7'h3F);
        irq_req = 4'b1000;
        #1 check("R9 held masked", 32'(evt_accept), 32'h0);
        mask_we = 1'b1; mask_wdata = 7'h00;
        @(negedge clk);
        mask_we = 1'b0;
        #1 check("R9 held then taken", 32'(evt_id), 32'd9);
        check("R7 level3 handler", evt_handler, BASE + 32'd36);
        @(negedge clk);
        irq_req = '0;

        // R4: critical accepted with every mask set
        write_mask(7'h7F);
        crit_req = 4'b1100; dbg_req = 1'b1;
        #1 check("R4 crit under full mask", 32'(evt_id), 32'd3);
        @(negedge clk);
        crit_req = '0; dbg_req = 1'b0;

        // Sweep: every mask value against pseudo-random request patterns
        for (int m = 0; m < 128; m++) begin
            for (int p = 0; p < 24; p++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                ir = lfsr[3:0];  ex = lfsr[7:4];  cr = lfsr[11:8];  db = lfsr[12];
                if (p[0]) begin ir = ir & lfsr[15:12]; ex = ex & lfsr[11:8]; end
                if (p % 4 != 0) cr = '0;
                if (p % 3 != 0) db = 1'b0;
                if (p % 6 == 5) ex = '0;
                write_mask(7'(m));
                check("R8 sweep write", 32'(mask_q), 32'(m));
                irq_req = ir; exc_req = ex; crit_req = cr; dbg_req = db;
                model(7'(m), ir, ex, cr, db, acc, id, mode, set);
                #1;
                check("R3 R4 sweep accept", 32'(evt_accept), 32'(acc));
                check("R2 sweep id", 32'(evt_id), 32'(id));
                check("R6 sweep mode", 32'(evt_mode), 32'(mode));
                check("R7 sweep handler", evt_handler, acc ? BASE + 32'(id) * 4 : 32'h0);
                @(negedge clk);
                irq_req = '0; exc_req = '0; crit_req = '0; dbg_req = 1'b0;
                check("R5 sweep mask", 32'(mask_q), 32'(7'(m) | set));
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule